// File: doc/BRIEF.md
# Processor Interrupt Acceptance Controller

This block picks, at each instruction boundary of a processor core, the single event the core will take next. It sees four kinds of request: a synchronous exception from the execution pipeline, a nonmaskable interrupt, a maskable request on the external interrupt pin, and a maskable request from the local interrupt controller. A nonmaskable interrupt can arrive either as a rising edge on a dedicated pin or as a one-cycle pulse that marks a received bus message with nonmaskable delivery mode. The block treats both arrivals the same way.

The block holds three pieces of state. The first is an interrupt-enable flag, which software sets and clears with pulses and which entry through an interrupt gate clears. The second is a blocked flag that stops a second nonmaskable interrupt from nesting inside the first. The third is a one-deep latch for a nonmaskable interrupt that arrives while the blocked flag is set. The enable flag gates only the two maskable sources. The blocked flag is set when a true nonmaskable interrupt is accepted. Only the return-from-interrupt pulse clears it, and the pulse clears it even when that return instruction itself faults.

When the block accepts an event it raises a registered take strobe for one cycle. In the same cycle it shows the 8-bit vector, a 2-bit source class and a one-cycle acknowledge to the source that won.

Top module: `irq_accept_ctl`

## Requirements
- R1: After reset the take strobe, every acknowledge, the enable flag, the blocked flag and the pending latch are all 0, and a boundary with no request produces no take.
- R2: A rising edge on the nonmaskable pin, or a message pulse, is accepted at a boundary in that same cycle. On the next cycle the take strobe is 1, the vector is 2 and the class is 1. A pin held high does not trigger again.
- R3: Accepting a true nonmaskable interrupt sets the blocked flag. While the flag is set, no further nonmaskable interrupt is taken.
- R4: A nonmaskable arrival while blocked is latched as one pending event, and further arrivals are dropped. The pending event is taken at the first boundary where the blocked flag is cleared, and a return pulse in the same cycle as that boundary counts as cleared.
- R5: A return pulse clears the blocked flag even when an exception is accepted at the same boundary. The exception is taken first, and the blocked flag reads 0 on the next cycle.
- R6: While the enable flag is 0, requests from the pin (class 2) and from the local controller (class 3) are never taken. While it is 1, they are taken with their own vector.
- R7: The enable flag has no effect on exceptions (class 0, vector from the requester) or on nonmaskable interrupts.
- R8: A maskable request with vector 2 is taken as class 2 or 3 and leaves the blocked flag at 0.
- R9: The enable flag is set by its set pulse and cleared by its clear pulse. A gate-entry pulse clears it and wins over a set pulse in the same cycle.
- R10: Priority at a boundary runs exception, then unblocked nonmaskable, then local controller, then pin. Exactly one source is taken, and only that source's acknowledge pulses, for one cycle.
- R11: Without a boundary pulse nothing is taken, and a held request is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary; an event may be accepted in this cycle |
| nmi_pin_i | input | 1 | Nonmaskable pin; rising edge sensitive |
| nmi_msg_i | input | 1 | One-cycle pulse: bus message with nonmaskable delivery mode |
| intr_req_i | input | 1 | Maskable request from the external pin (level) |
| intr_vec_i | input | 8 | Vector supplied with the pin request |
| lic_req_i | input | 1 | Maskable request from the local interrupt controller (level) |
| lic_vec_i | input | 8 | Vector supplied by the local controller |
| exc_req_i | input | 1 | Synchronous exception request (level) |
| exc_vec_i | input | 8 | Exception vector |
| iret_i | input | 1 | Return-from-interrupt executed pulse |
| gate_entry_i | input | 1 | Handler entered through an interrupt gate |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| take_o | output | 1 | One-cycle accept strobe |
| take_vec_o | output | 8 | Vector of the accepted event |
| take_class_o | output | 2 | 0 exception, 1 nonmaskable, 2 pin, 3 local controller |
| ack_exc_o | output | 1 | Acknowledge to the exception source |
| ack_nmi_o | output | 1 | Acknowledge to the nonmaskable logic |
| ack_intr_o | output | 1 | Acknowledge to the pin source |
| ack_lic_o | output | 1 | Acknowledge to the local controller |
| ie_o | output | 1 | Current enable flag |
| nmi_blocked_o | output | 1 | Current blocked flag |

## Verification
The bench targets a return instruction that faults at the same boundary where an exception is pending. A design that clears the blocked flag late would leave it at 1, and the nonmaskable interrupt queued behind the exception would stall. The bench sends two nonmaskable arrivals while blocked. A design without a one-deep latch would either lose the first arrival or take the event twice after the return. The bench also sends a maskable request with vector 2. A design that decides by vector rather than by source would set the blocked flag and lock out the real nonmaskable interrupt that follows. Finally, it raises all four sources at once to show the fixed order, and holds the pin high to show that a level does not take a second event.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    // source class reported with every accepted event; value is also ack index
    typedef enum logic [1:0] {
        SRC_EXC = 2'd0,
        SRC_NMI = 2'd1,
        SRC_PIN = 2'd2,
        SRC_LOC = 2'd3
    } src_e;

    localparam int NUM_SRC = 4;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl_i;
        rise_o   = lvl_i & ~s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_accept_pkg::*;
#(
    parameter bit LOC_FIRST = 1'b1
) (
    input  logic exc_ok_i,
    input  logic nmi_ok_i,
    input  logic loc_ok_i,
    input  logic pin_ok_i,
    output logic hit_o,
    output src_e src_o
);
    logic  mask_hit;
    src_e  mask_src;

    generate
        if (LOC_FIRST) begin : g_loc_first
            always_comb begin
                mask_hit = loc_ok_i | pin_ok_i;
                mask_src = loc_ok_i ? SRC_LOC : SRC_PIN;
            end
        end else begin : g_pin_first
            always_comb begin
                mask_hit = loc_ok_i | pin_ok_i;
                mask_src = pin_ok_i ? SRC_PIN : SRC_LOC;
            end
        end
    endgenerate

    always_comb begin
        hit_o = 1'b1;
        src_o = SRC_EXC;
        if (exc_ok_i)      src_o = SRC_EXC;
        else if (nmi_ok_i) src_o = SRC_NMI;
        else if (mask_hit) src_o = mask_src;
        else               hit_o = 1'b0;
    end
endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
    import irq_accept_pkg::*;
#(
    parameter int          VW        = 8,
    parameter logic [VW-1:0] NMI_VEC = VW'(2),
    parameter bit          LOC_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary_i,
    input  logic          nmi_pin_i,
    input  logic          nmi_msg_i,
    input  logic          intr_req_i,
    input  logic [VW-1:0] intr_vec_i,
    input  logic          lic_req_i,
    input  logic [VW-1:0] lic_vec_i,
    input  logic          exc_req_i,
    input  logic [VW-1:0] exc_vec_i,
    input  logic          iret_i,
    input  logic          gate_entry_i,
    input  logic          ie_set_i,
    input  logic          ie_clr_i,
    output logic          take_o,
    output logic [VW-1:0] take_vec_o,
    output logic [1:0]    take_class_o,
    output logic          ack_exc_o,
    output logic          ack_nmi_o,
    output logic          ack_intr_o,
    output logic          ack_lic_o,
    output logic          ie_o,
    output logic          nmi_blocked_o
);
    typedef struct packed {
        logic               pend;
        logic               blk;
        logic               ie;
        logic               take;
        src_e               cls;
        logic [VW-1:0]      vec;
        logic [NUM_SRC-1:0] ack;
    } st_t;

    st_t  s_d, s_q;
    logic pin_rise;
    logic nmi_arr, nmi_avail, blk_eff, took_nmi;
    logic exc_ok, nmi_ok, loc_ok, pin_ok;
    logic hit;
    src_e src;

    irq_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (nmi_pin_i),
        .rise_o (pin_rise)
    );

    // a return pulse in the boundary cycle unblocks before the decision
    always_comb begin
        nmi_arr   = pin_rise | nmi_msg_i;
        nmi_avail = s_q.pend | nmi_arr;
        blk_eff   = s_q.blk & ~iret_i;
        exc_ok    = boundary_i & exc_req_i;
        nmi_ok    = boundary_i & nmi_avail & ~blk_eff;
        loc_ok    = boundary_i & s_q.ie & lic_req_i;
        pin_ok    = boundary_i & s_q.ie & intr_req_i;
    end

    irq_pick #(.LOC_FIRST(LOC_FIRST)) u_pick (
        .exc_ok_i (exc_ok),
        .nmi_ok_i (nmi_ok),
        .loc_ok_i (loc_ok),
        .pin_ok_i (pin_ok),
        .hit_o    (hit),
        .src_o    (src)
    );

    always_comb begin
        s_d      = s_q;
        took_nmi = hit && (src == SRC_NMI);

        s_d.take = hit;
        s_d.cls  = hit ? src : SRC_EXC;
        s_d.ack  = '0;
        s_d.vec  = '0;
        if (hit) begin
            s_d.ack[src] = 1'b1;
            unique case (src)
                SRC_EXC: s_d.vec = exc_vec_i;
                SRC_NMI: s_d.vec = NMI_VEC;
                SRC_PIN: s_d.vec = intr_vec_i;
                default: s_d.vec = lic_vec_i;
            endcase
        end

        // one-deep latch: an arrival coinciding with consumption stays pending
        s_d.pend = took_nmi ? (s_q.pend & nmi_arr) : nmi_avail;
        s_d.blk  = took_nmi | blk_eff;

        if (gate_entry_i || ie_clr_i) s_d.ie = 1'b0;
        else if (ie_set_i)            s_d.ie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign take_o        = s_q.take;
    assign take_vec_o    = s_q.vec;
    assign take_class_o  = s_q.cls;
    assign ack_exc_o     = s_q.ack[SRC_EXC];
    assign ack_nmi_o     = s_q.ack[SRC_NMI];
    assign ack_intr_o    = s_q.ack[SRC_PIN];
    assign ack_lic_o     = s_q.ack[SRC_LOC];
    assign ie_o          = s_q.ie;
    assign nmi_blocked_o = s_q.blk;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boundary_i,
    input logic          iret_i,
    input logic          gate_entry_i,
    input logic          take_o,
    input logic [VW-1:0] take_vec_o,
    input logic [1:0]    take_class_o,
    input logic          ack_exc_o,
    input logic          ack_nmi_o,
    input logic          ack_intr_o,
    input logic          ack_lic_o,
    input logic          ie_o,
    input logic          nmi_blocked_o
);
    p_one_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}));

    p_take_has_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $countones({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}) == 1);

    p_take_needs_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));

    p_nmi_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_class_o == 2'd1) |-> take_vec_o == VW'(2));

    p_nmi_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_class_o == 2'd1) |-> nmi_blocked_o);

    p_block_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_blocked_o && !iret_i) |=> nmi_blocked_o);

    p_iret_unblocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_i && !(boundary_i)) |=> !nmi_blocked_o);

    p_mask_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_class_o[1]) |-> $past(ie_o));

    p_gate_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_entry_i |=> !ie_o);
endmodule

bind irq_accept_ctl irq_accept_chk #(.VW(VW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .boundary_i    (boundary_i),
    .iret_i        (iret_i),
    .gate_entry_i  (gate_entry_i),
    .take_o        (take_o),
    .take_vec_o    (take_vec_o),
    .take_class_o  (take_class_o),
    .ack_exc_o     (ack_exc_o),
    .ack_nmi_o     (ack_nmi_o),
    .ack_intr_o    (ack_intr_o),
    .ack_lic_o     (ack_lic_o),
    .ie_o          (ie_o),
    .nmi_blocked_o (nmi_blocked_o)
);

// File: tb/irq_accept_ctl_test.sv
module irq_accept_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       boundary_i, nmi_pin_i, nmi_msg_i;
    logic       intr_req_i, lic_req_i, exc_req_i;
    logic [7:0] intr_vec_i, lic_vec_i, exc_vec_i;
    logic       iret_i, gate_entry_i, ie_set_i, ie_clr_i;
    logic       take_o;
    logic [7:0] take_vec_o;
    logic [1:0] take_class_o;
    logic       ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o;
    logic       ie_o, nmi_blocked_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_accept_ctl uut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .nmi_pin_i(nmi_pin_i), .nmi_msg_i(nmi_msg_i),
        .intr_req_i(intr_req_i), .intr_vec_i(intr_vec_i),
        .lic_req_i(lic_req_i), .lic_vec_i(lic_vec_i),
        .exc_req_i(exc_req_i), .exc_vec_i(exc_vec_i),
        .iret_i(iret_i), .gate_entry_i(gate_entry_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .take_o(take_o), .take_vec_o(take_vec_o), .take_class_o(take_class_o),
        .ack_exc_o(ack_exc_o), .ack_nmi_o(ack_nmi_o),
        .ack_intr_o(ack_intr_o), .ack_lic_o(ack_lic_o),
        .ie_o(ie_o), .nmi_blocked_o(nmi_blocked_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // take, vector, class in one go
    task automatic chk_take(input string req, input int t, input int v, input int c);
        chk({req, " take"}, int'(take_o), t);
        if (t != 0) begin
            chk({req, " vec"}, int'(take_vec_o), v);
            chk({req, " class"}, int'(take_class_o), c);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        boundary_i = 0; nmi_msg_i = 0; intr_req_i = 0; lic_req_i = 0;
        exc_req_i = 0; iret_i = 0; gate_entry_i = 0; ie_set_i = 0; ie_clr_i = 0;
        intr_vec_i = 0; lic_vec_i = 0; exc_vec_i = 0;
    endtask

    task automatic do_reset();
        quiet();
        nmi_pin_i = 0;
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
    endtask

    task automatic set_ie();
        ie_set_i = 1; step(); ie_set_i = 0;
    endtask

    task automatic take_first_nmi();
        nmi_msg_i = 1; boundary_i = 1; step();
        nmi_msg_i = 0; boundary_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 take", int'(take_o), 0);
        chk("R1 ie", int'(ie_o), 0);
        chk("R1 blocked", int'(nmi_blocked_o), 0);
        chk("R1 acks", int'({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}), 0);
        boundary_i = 1; step(); boundary_i = 0;
        chk_take("R1 idle boundary (no pending)", 0, 0, 0);
    endtask

    task automatic t_nmi_sources();
        do_reset();
        nmi_pin_i = 1; boundary_i = 1; step(); boundary_i = 0;
        chk_take("R2 pin edge", 1, 2, 1);
        chk("R2 ack nmi", int'(ack_nmi_o), 1);
        iret_i = 1; step(); iret_i = 0;
        chk("R2 ack pulse ends", int'(ack_nmi_o), 0);
        boundary_i = 1; step(); boundary_i = 0;
        chk_take("R2 held pin no retrigger", 0, 0, 0);
        nmi_msg_i = 1; boundary_i = 1; step(); nmi_msg_i = 0; boundary_i = 0;
        chk_take("R2 message", 1, 2, 1);
        nmi_pin_i = 0;
    endtask

    task automatic t_block_pending();
        do_reset();
        take_first_nmi();
        chk("R3 blocked set", int'(nmi_blocked_o), 1);
        nmi_msg_i = 1; step(); nmi_msg_i = 0; step();
        nmi_pin_i = 1; step(); nmi_pin_i = 0;
        boundary_i = 1; step(); boundary_i = 0;
        chk_take("R3 blocked no take", 0, 0, 0);
        iret_i = 1; boundary_i = 1; step(); iret_i = 0; boundary_i = 0;
        chk_take("R4 pending taken on unblock", 1, 2, 1);
        iret_i = 1; step(); iret_i = 0;
        boundary_i = 1; step(); boundary_i = 0;
        chk_take("R4 extra arrival dropped", 0, 0, 0);
        chk("R4 unblocked", int'(nmi_blocked_o), 0);
    endtask

    task automatic t_iret_fault();
        do_reset();
        take_first_nmi();
        nmi_msg_i = 1; step(); nmi_msg_i = 0;
        iret_i = 1; exc_req_i = 1; exc_vec_i = 8'd13; boundary_i = 1; step();
        iret_i = 0; exc_req_i = 0; boundary_i = 0;
        chk_take("R5 exception first", 1, 13, 0);
        chk("R5 unblocked at fault", int'(nmi_blocked_o), 0);
        boundary_i = 1; step(); boundary_i = 0;
        chk_take("R5 pending nmi next", 1, 2, 1);
    endtask

    task automatic t_mask();
        do_reset();
        intr_req_i = 1; intr_vec_i = 8'h40; boundary_i = 1; step();
        chk_take("R6 pin masked", 0, 0, 0);
        intr_req_i = 0; lic_req_i = 1; lic_vec_i = 8'h51; step();
        chk_take("R6 local masked", 0, 0, 0);
        lic_req_i = 0; exc_req_i = 1; exc_vec_i = 8'd6; step(); exc_req_i = 0;
        chk_take("R7 exception with ie=0", 1, 6, 0);
        nmi_msg_i = 1; step(); nmi_msg_i = 0; boundary_i = 0;
        chk_take("R7 nmi with ie=0", 1, 2, 1);
        set_ie();
        chk("R9 set pulse", int'(ie_o), 1);
        intr_req_i = 1; boundary_i = 1; step(); intr_req_i = 0;
        chk_take("R6 pin enabled", 1, 8'h40, 2);
        chk("R6 ack pin", int'(ack_intr_o), 1);
        lic_req_i = 1; step(); lic_req_i = 0; boundary_i = 0;
        chk_take("R6 local enabled", 1, 8'h51, 3);
        ie_clr_i = 1; step(); ie_clr_i = 0;
        chk("R9 clear pulse", int'(ie_o), 0);
    endtask

    task automatic t_fake_nmi();
        do_reset();
        set_ie();
        intr_req_i = 1; intr_vec_i = 8'd2; boundary_i = 1; step();
        intr_req_i = 0; boundary_i = 0;
        chk_take("R8 vector 2 maskable", 1, 2, 2);
        chk("R8 not blocked", int'(nmi_blocked_o), 0);
        nmi_msg_i = 1; boundary_i = 1; step(); nmi_msg_i = 0; boundary_i = 0;
        chk_take("R8 real nmi still taken", 1, 2, 1);
    endtask

    task automatic t_gate();
        do_reset();
        set_ie();
        gate_entry_i = 1; ie_set_i = 1; step(); gate_entry_i = 0; ie_set_i = 0;
        chk("R9 gate beats set", int'(ie_o), 0);
        lic_req_i = 1; lic_vec_i = 8'h70; boundary_i = 1; step();
        lic_req_i = 0; boundary_i = 0;
        chk_take("R9 masked after gate", 0, 0, 0);
    endtask

    task automatic t_prio();
        do_reset();
        set_ie();
        exc_req_i = 1; exc_vec_i = 8'd14; nmi_pin_i = 1;
        lic_req_i = 1; lic_vec_i = 8'h33; intr_req_i = 1; intr_vec_i = 8'h44;
        boundary_i = 1; step(); exc_req_i = 0;
        chk_take("R10 exception wins", 1, 14, 0);
        chk("R10 only exc ack", int'({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}), 8);
        step();
        chk_take("R10 nmi second", 1, 2, 1);
        step(); lic_req_i = 0;
        chk_take("R10 local third", 1, 8'h33, 3);
        step(); boundary_i = 0;
        chk_take("R10 pin last", 1, 8'h44, 2);
        chk("R10 only pin ack", int'({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}), 2);
        step(); intr_req_i = 0;
        chk("R10 ack one cycle", int'({ack_exc_o, ack_nmi_o, ack_intr_o, ack_lic_o}), 0);
        nmi_pin_i = 0;
    endtask

    task automatic t_no_boundary();
        do_reset();
        set_ie();
        exc_req_i = 1; exc_vec_i = 8'd3;
        repeat (3) begin
            step();
            chk_take("R11 no boundary", 0, 0, 0);
        end
        boundary_i = 1; step(); boundary_i = 0; exc_req_i = 0;
        chk_take("R11 held request taken", 1, 3, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nmi_sources();
        t_block_pending();
        t_iret_fault();
        t_mask();
        t_fake_nmi();
        t_gate();
        t_prio();
        t_no_boundary();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule